// File: doc/BRIEF.md
# Two-Channel Edge-Triggered Interrupt Detector

This block watches two external input pins and turns qualified transitions on them into interrupt requests. Every pin is first resynchronised and then passed through a sampled glitch filter. Only a level that has held steady for a programmed number of filter samples is accepted. The filtered level feeds an edge detector that software sets to react to rising transitions, falling transitions, both, or neither. A detected edge sets a sticky source flag for that channel. The channel's request line is raised while both its flag and its enable bit are set.

The two channels share one 8-bit control register, and a single write updates both channels' fields. Each source flag can only be cleared by writing 0 to it; writing 1 to it has no effect. The wake output tells a power controller that an enabled flag is pending. Before the system clock is stopped, the controller raises `stop_req`. A capture stage then records the selected edges directly on the raw pins, with no clock involved, and drives `wake` at once. When the clock runs again, the captured event is synchronised into the source flag.

Top module: `eirq_unit`

## Requirements
- R1: A synchronous reset clears the whole control register, so `ctl_rdata` reads 8'h00, `irq` is 2'b00 and `wake` is 0.
- R2: Channel k owns control bits [4k+3:4k]. Bits [4k+1:4k] are the edge select: 00 ignores both transitions, 01 reacts to rising transitions only, 10 to falling transitions only, and 11 to both. Bit 4k+2 is the enable and bit 4k+3 is the source flag.
- R3: A pin level is accepted only after it has been seen at STABLE_N consecutive filter samples, taken one every SAMPLE_DIV clocks. A pulse of 3 clocks is never accepted with the defaults (4 samples, 2 clocks apart). A level held for 30 clocks always is.
- R4: A selected edge sets the channel's source flag even while its enable bit is 0. In that case `irq` for the channel stays 0.
- R5: `irq[k]` is 1 exactly while source flag k and enable k are both 1.
- R6: A control write of 0 to a flag bit clears that flag. A write of 1 leaves the flag unchanged, so software can never set a flag.
- R7: The channels are independent: an edge on one pin never changes the other channel's fields or request.
- R8: When no stop is requested, `wake` equals the OR of both channels' enabled flags.
- R9: While `stop_req` is high and the clock is stopped, a selected edge on the pin of an enabled channel raises `wake` without any clock edge. Once the clock restarts, that channel's flag becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped while `stop_req` is high |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 2 | Raw, asynchronous external input pins |
| stop_req | input | 1 | Arms the clockless edge capture before the clock is stopped |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: per channel select, enable and flag |
| ctl_rdata | output | 8 | Current control register contents |
| irq | output | 2 | Per-channel interrupt requests |
| wake | output | 1 | Wake-up request |

## Verification
A filter counter that fails to restart shows up at the ports in two ways. Short pulses start to set flags, or legitimate levels never reach the flag. Either effect is visible on `ctl_rdata` within about a dozen clocks of the pin change. A wrong edge-select decode or a flag that software can set is exposed by the next read after the stimulus. The stop path is the one fault that shows up without any clock: `wake` must rise within nanoseconds of the pin edge while the clock is frozen, and the flag must appear a few cycles after the clock restarts.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int FLD_W = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // one channel's field, flag in the most significant position
  typedef struct packed {
    logic      flag;
    logic      en;
    edge_sel_e sel;
  } chan_cfg_t;
endpackage

// File: rtl/eirq_filter.sv
module eirq_filter #(
  parameter int  STABLE_N = 4,
  parameter bit  IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic pin_raw,
  output logic lvl
);
  localparam int CW = $clog2(STABLE_N + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {2{IDLE_LVL}};
    else     sync_q <= {sync_q[0], pin_raw};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl   <= IDLE_LVL;
      run_q <= '0;
    end else if (smp_en) begin
      if (sync_q[1] != lvl) begin
        if (run_q == CW'(STABLE_N - 1)) begin
          lvl   <= sync_q[1];
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge
  import eirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  edge_sel_e sel,
  output logic      hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign hit = (sel[0] & lvl & ~prev_q) | (sel[1] & ~lvl & prev_q);
endmodule

// File: rtl/eirq_stop_catch.sv
module eirq_stop_catch
  import eirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      arm,
  input  edge_sel_e sel,
  input  logic      pin_raw,
  output logic      caught_async,
  output logic      set_pulse
);
  logic       arm_q;
  logic       clr;
  logic       rise_c;
  logic       fall_c;
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= arm;
  end

  assign clr = ~arm_q;

  always_ff @(posedge pin_raw or posedge clr) begin
    if (clr)         rise_c <= 1'b0;
    else if (sel[0]) rise_c <= 1'b1;
  end

  always_ff @(negedge pin_raw or posedge clr) begin
    if (clr)         fall_c <= 1'b0;
    else if (sel[1]) fall_c <= 1'b1;
  end

  assign caught_async = rise_c | fall_c;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], caught_async};
  end

  assign set_pulse = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/eirq_channel.sv
module eirq_channel
  import eirq_pkg::*;
#(
  parameter int STABLE_N = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      smp_en,
  input  logic      pin_raw,
  input  logic      stop_req,
  input  chan_cfg_t cfg,
  output logic      set_evt,
  output logic      caught_async
);
  logic lvl;
  logic hit;
  logic stop_set;
  logic arm;

  eirq_filter #(.STABLE_N(STABLE_N), .IDLE_LVL(1'b0)) u_filt (
    .clk(clk), .rst(rst), .smp_en(smp_en), .pin_raw(pin_raw), .lvl(lvl)
  );

  eirq_edge u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .sel(cfg.sel), .hit(hit)
  );

  assign arm = stop_req & cfg.en & (cfg.sel != EDGE_OFF);

  eirq_stop_catch u_catch (
    .clk(clk), .rst(rst), .arm(arm), .sel(cfg.sel), .pin_raw(pin_raw),
    .caught_async(caught_async), .set_pulse(stop_set)
  );

  assign set_evt = hit | stop_set;
endmodule

// File: rtl/eirq_unit.sv
module eirq_unit
  import eirq_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int SAMPLE_DIV = 2,
  parameter int STABLE_N   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       pin_in,
  input  logic                 stop_req,
  input  logic                 ctl_wr,
  input  logic [NCH*FLD_W-1:0] ctl_wdata,
  output logic [NCH*FLD_W-1:0] ctl_rdata,
  output logic [NCH-1:0]       irq,
  output logic                 wake
);
  localparam int DW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic             smp_en;
  logic [NCH-1:0]   set_evt;
  logic [NCH-1:0]   caught;
  chan_cfg_t        cfg_q [NCH];
  chan_cfg_t        cfg_n [NCH];
  logic [NCH-1:0]   irq_q;

  generate
    if (SAMPLE_DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                                div_q <= '0;
        else if (div_q == DW'(SAMPLE_DIV - 1))  div_q <= '0;
        else                                    div_q <= div_q + 1'b1;
      end
      assign smp_en = (div_q == DW'(SAMPLE_DIV - 1));
    end else begin : g_nodiv
      assign smp_en = 1'b1;
    end
  endgenerate

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      chan_cfg_t wr_f;
      assign wr_f = chan_cfg_t'(ctl_wdata[k*FLD_W +: FLD_W]);

      eirq_channel #(.STABLE_N(STABLE_N)) u_ch (
        .clk(clk), .rst(rst), .smp_en(smp_en), .pin_raw(pin_in[k]),
        .stop_req(stop_req), .cfg(cfg_q[k]),
        .set_evt(set_evt[k]), .caught_async(caught[k])
      );

      always_comb begin
        cfg_n[k] = cfg_q[k];
        if (ctl_wr) begin
          cfg_n[k].sel  = wr_f.sel;
          cfg_n[k].en   = wr_f.en;
          cfg_n[k].flag = cfg_q[k].flag & wr_f.flag;
        end
        if (set_evt[k]) cfg_n[k].flag = 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_q[k] <= '0;
          irq_q[k] <= 1'b0;
        end else begin
          cfg_q[k] <= cfg_n[k];
          irq_q[k] <= cfg_n[k].flag & cfg_n[k].en;
        end
      end

      assign ctl_rdata[k*FLD_W +: FLD_W] = cfg_q[k];
    end
  endgenerate

  assign irq  = irq_q;
  assign wake = (|irq_q) | (|caught);
endmodule

// File: rtl/eirq_unit_chk.sv
module eirq_unit_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_req,
  input logic [NCH*4-1:0] ctl_rdata,
  input logic [NCH-1:0]   irq,
  input logic             wake,
  input logic [NCH-1:0]   set_evt
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ctl_rdata == '0 && irq == '0));

  a_r8_wake_is_or: assert property (@(posedge clk) disable iff (rst)
    (!stop_req && !$past(stop_req)) |-> (wake == |irq));

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_a
      a_r5_irq_matches: assert property (@(posedge clk) disable iff (rst)
        irq[k] == (ctl_rdata[4*k+3] & ctl_rdata[4*k+2]));

      a_r6_flag_only_by_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_rdata[4*k+3]) |-> $past(set_evt[k]));

      a_r2_off_never_sets: assert property (@(posedge clk) disable iff (rst)
        set_evt[k] |-> (ctl_rdata[4*k+1 -: 2] != 2'b00));
    end
  endgenerate
endmodule

bind eirq_unit eirq_unit_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .ctl_rdata(ctl_rdata),
  .irq(irq), .wake(wake), .set_evt(set_evt)
);

// File: tb/eirq_unit_test.sv
`timescale 1ns/1ps
module eirq_unit_test;
  typedef struct {
    string      tag;
    logic [7:0] ctl;
    logic [1:0] irq;
    logic       wake;
  } exp_t;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst = 1'b1;
  logic [1:0] pin_in = 2'b00;
  logic       stop_req = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic [1:0] irq;
  logic       wake;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  eirq_unit uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .stop_req(stop_req),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq(irq), .wake(wake)
  );

  initial forever begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // driver side: queue expectation, give the monitor time to compare
  task automatic expect_state(input string tag, input logic [7:0] c,
                              input logic [1:0] i, input logic w);
    exp_t e;
    e.tag = tag; e.ctl = c; e.irq = i; e.wake = w;
    exp_q.push_back(e);
    #2;
  endtask

  // monitor: compares outputs against each queued expectation
  initial forever begin
    exp_t e;
    wait (exp_q.size() != 0);
    #1;
    e = exp_q.pop_front();
    checks++;
    if (ctl_rdata !== e.ctl) begin
      failures++;
      $display("FAIL %s ctl actual=%h expected=%h", e.tag, ctl_rdata, e.ctl);
    end
    checks++;
    if (irq !== e.irq) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.irq);
    end
    checks++;
    if (wake !== e.wake) begin
      failures++;
      $display("FAIL %s wake actual=%b expected=%b", e.tag, wake, e.wake);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    expect_state("R1 reset state", 8'h00, 2'b00, 1'b0);

    // ch0 rising+enabled, ch1 falling+disabled
    wr(8'h25);
    expect_state("R2 readback", 8'h25, 2'b00, 1'b0);

    pin_in[0] = 1'b1; cyc(30);
    expect_state("R2 R5 R7 R8 rise on ch0", 8'h2D, 2'b01, 1'b1);

    wr(8'h25); cyc(1);
    expect_state("R6 clear flag0", 8'h25, 2'b00, 1'b0);

    pin_in[0] = 1'b0; cyc(30);
    expect_state("R2 falling ignored on rise select", 8'h25, 2'b00, 1'b0);

    pin_in[1] = 1'b1; cyc(30);
    expect_state("R2 rising ignored on fall select", 8'h25, 2'b00, 1'b0);

    pin_in[1] = 1'b0; cyc(30);
    expect_state("R4 R7 R8 fall sets ch1 flag, enable off", 8'hA5, 2'b00, 1'b0);

    wr(8'hAD); cyc(1);
    expect_state("R6 writing one sets nothing", 8'hA5, 2'b00, 1'b0);

    wr(8'h00); cyc(1);
    expect_state("R6 clear all", 8'h00, 2'b00, 1'b0);

    wr(8'h07); cyc(1);
    pin_in[0] = 1'b1; cyc(3); pin_in[0] = 1'b0; cyc(30);
    expect_state("R3 short pulse rejected", 8'h07, 2'b00, 1'b0);

    pin_in[0] = 1'b1; cyc(30);
    expect_state("R2 R3 both-edge select rise", 8'h0F, 2'b01, 1'b1);
    wr(8'h07); cyc(1);
    expect_state("R6 clear before fall", 8'h07, 2'b00, 1'b0);
    pin_in[0] = 1'b0; cyc(30);
    expect_state("R2 both-edge select fall", 8'h0F, 2'b01, 1'b1);

    wr(8'h07); cyc(1);
    pin_in[1] = 1'b1; cyc(30);
    expect_state("R2 select off on ch1 ignores edges", 8'h07, 2'b00, 1'b0);

    // clockless capture
    stop_req = 1'b1; cyc(3);
    clk_run = 1'b0;
    #40;
    expect_state("R9 no wake before edge", 8'h07, 2'b00, 1'b0);
    pin_in[0] = 1'b1;
    #10;
    expect_state("R9 wake without clock", 8'h07, 2'b00, 1'b1);
    #40;
    clk_run = 1'b1;
    cyc(10);
    expect_state("R9 flag after restart", 8'h0F, 2'b01, 1'b1);
    stop_req = 1'b0; cyc(3);
    wr(8'h07); cyc(3);
    expect_state("R8 wake drops after clear", 8'h07, 2'b00, 1'b0);

    done = 1'b1;
    #5;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule